// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This unit sits beside a FIFO's storage and turns the FIFO's occupancy into two programmable warning flags. It holds an empty-side threshold and a full-side threshold. It drives an active-low almost-empty flag, computed from the stored word count, and an active-low almost-full flag, computed from the free-location count. The storage array and its pointers are outside the unit. The counts come in as inputs.

The thresholds have three sources. A master reset loads one of eight default pairs and fixes the loading method and the parallel field layout. After reset the thresholds can be replaced in one of two ways. In serial loading they are shifted in one bit per write clock. In parallel loading they are taken from the 36-bit data bus, one offset per write. Either way, they can be read back in parallel on the read clock. A partial reset restarts the load and read-back sequences but keeps every programmed value and mode.

Top module: `pflag_offset_unit`

## Requirements
- R1: On each rising `rd_clk` edge outside reset, `ae_n` is loaded with 1 when `word_cnt` is greater than or equal to the empty offset, and with 0 when it is smaller. Both resets drive `ae_n` to 0.
- R2: On each rising `wr_clk` edge outside reset, `af_n` is loaded with 1 when `free_cnt` is greater than the full offset, and with 0 when it is less than or equal to it. Both resets drive `af_n` to 1.
- R3: While `mrst_n` is low, the 3-bit code {`ld`,`dflt_sel[1]`,`dflt_sel[0]`} = k sets both offsets to 2^(k+3)-1.
  - `ld` high selects parallel loading and `ld` low selects serial loading.
  - `parity_cfg` is latched as the layout mode.
  - `dout` is cleared to zero.
- R4: In serial mode, each `wr_clk` edge with `ser_en` and `ld` high shifts in `ser_in`, least significant bit first. W bits fill the empty offset, and the next W bits fill the full offset. Then the sequence repeats. An offset changes only on the edge that carries its last bit.
- R5: In parallel mode, each `wr_clk` edge with `wr_en` and `ld` high loads one offset from `din`. Writes alternate between the empty offset and the full offset, starting with the empty offset, and wrap back to it after the full offset.
- R6: With the layout mode off, a parallel word supplies its offset from `din[W-1:0]`. Bits 8, 17 and 26 count as data, and bits 32 to 35 are ignored.
- R7: With the layout mode on, bits 8, 17, 26 and 35 of `din` are parity and are skipped. The offset is packed from the remaining bits in ascending order: 0-7, 9-16, 18-25 and 27-34.
- R8: The method not selected at master reset has no effect. Serial strobes are ignored in parallel mode, and parallel writes are ignored in serial mode.
- R9: Each `rd_clk` edge with `rd_en` and `ld` high puts one offset on `dout`, using the latched layout with any parity positions zero.
  - Read-backs alternate empty, full, empty and so on, starting with empty.
  - At all other edges outside reset, `dout` holds its value.
- R10: While `prst_n` is low, the offsets, the loading method and the layout mode are kept. The parallel write sequence, the serial bit position and the read-back sequence restart at the empty offset, and `dout` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock: offset loading, almost-full flag |
| rd_clk | input | 1 | Read-side clock: read-back, almost-empty flag |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| dflt_sel | input | 2 | Default offset select, sampled during master reset |
| parity_cfg | input | 1 | Parity-skipping layout select, sampled during master reset |
| ld | input | 1 | Offset access strobe; also the method and default select bit during master reset |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset data |
| wr_en | input | 1 | Parallel write enable |
| rd_en | input | 1 | Read-back enable |
| din | input | 36 | Parallel offset data |
| word_cnt | input | CNT_W | Words currently stored |
| free_cnt | input | CNT_W | Free locations currently available |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| dout | output | 36 | Offset read-back data |

## Verification
The flags are driven one step below, at, and one step above each offset. This shows that the almost-empty test includes the equality case and that the almost-full test excludes it. Serial loading is interrupted after one bit short of a full offset to show that the threshold has not yet moved. It is also broken off by a partial reset, which shows that the bit position restarts. Parallel words carry set parity bits and set upper bits, so the two field layouts give different offsets. A third write checks the wrap back to the empty offset. Each method's strobes are also driven in the other mode, and read-back right after a partial reset shows that the read order restarts while the values survive.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

   // Default threshold for reset code k: 2^(k+3)-1.
   function automatic logic [31:0] dflt_offset(input logic [2:0] k);
      return (32'd8 << k) - 32'd1;
   endfunction

   // Gather offset bits from a bus word, optionally skipping the parity slots.
   function automatic logic [31:0] field_unpack(input logic [35:0] d, input logic skip_par);
      if (skip_par)
         return {d[34:27], d[25:18], d[16:9], d[7:0]};
      return d[31:0];
   endfunction

   // Spread an offset back onto a bus word; parity slots read as zero.
   function automatic logic [35:0] field_pack(input logic [31:0] v, input logic skip_par);
      if (skip_par)
         return {1'b0, v[31:24], 1'b0, v[23:16], 1'b0, v[15:8], 1'b0, v[7:0]};
      return {4'b0000, v};
   endfunction

endpackage

// File: rtl/pfo_offset_regs.sv
module pfo_offset_regs #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         mrst_n,
   input  logic         prst_n,
   input  logic [1:0]   dflt_sel,
   input  logic         parity_cfg,
   input  logic         ld,
   input  logic         ser_en,
   input  logic         ser_in,
   input  logic         wr_en,
   input  logic [35:0]  din,
   output logic [W-1:0] ofs_e,
   output logic [W-1:0] ofs_f,
   output logic         ser_mode,
   output logic         skip_par
);
   import pfo_pkg::*;

   localparam int BCW = $clog2(2 * W);
   localparam logic [BCW-1:0] LAST_E = BCW'(W - 1);
   localparam logic [BCW-1:0] LAST_F = BCW'(2 * W - 1);

   logic [BCW-1:0] bit_pos;
   logic [W-1:0]   shreg;
   logic [W-1:0]   shnext;
   logic           par_sel;
   logic [31:0]    dflt_v;
   logic [31:0]    field_v;

   assign dflt_v  = dflt_offset({ld, dflt_sel});
   assign field_v = field_unpack(din, skip_par);
   assign shnext  = {ser_in, shreg[W-1:1]};

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         ser_mode <= !ld;
         skip_par <= parity_cfg;
         ofs_e    <= dflt_v[W-1:0];
         ofs_f    <= dflt_v[W-1:0];
         bit_pos  <= '0;
         shreg    <= '0;
         par_sel  <= 1'b0;
      end else if (!prst_n) begin
         bit_pos  <= '0;
         par_sel  <= 1'b0;
      end else begin
         if (ser_mode && ser_en && ld) begin
            shreg <= shnext;
            if (bit_pos == LAST_E) ofs_e <= shnext;
            if (bit_pos == LAST_F) ofs_f <= shnext;
            bit_pos <= (bit_pos == LAST_F) ? '0 : bit_pos + 1'b1;
         end
         if (!ser_mode && wr_en && ld) begin
            if (par_sel) ofs_f <= field_v[W-1:0];
            else         ofs_e <= field_v[W-1:0];
            par_sel <= !par_sel;
         end
      end
   end

endmodule

// File: rtl/pfo_readback.sv
module pfo_readback #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         mrst_n,
   input  logic         prst_n,
   input  logic         rd_en,
   input  logic         ld,
   input  logic [W-1:0] ofs_e,
   input  logic [W-1:0] ofs_f,
   input  logic         skip_par,
   output logic [35:0]  dout
);
   import pfo_pkg::*;

   logic         rd_sel;
   logic [W-1:0] pick;

   assign pick = rd_sel ? ofs_f : ofs_e;

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         rd_sel <= 1'b0;
         dout   <= '0;
      end else if (rd_en && ld) begin
         rd_sel <= !rd_sel;
         dout   <= field_pack({{(32 - W){1'b0}}, pick}, skip_par);
      end
   end

endmodule

// File: rtl/pfo_flag_cmp.sv
module pfo_flag_cmp #(
   parameter int CNT_W   = 16,
   parameter int W       = 15,
   parameter bit STRICT  = 1'b0,
   parameter bit RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [W-1:0]     ofs,
   output logic             flag_n
);
   logic [CNT_W-1:0] ofs_x;
   logic             above;

   assign ofs_x = {{(CNT_W - W){1'b0}}, ofs};

   generate
      if (STRICT) begin : g_gt
         assign above = cnt > ofs_x;
      end else begin : g_ge
         assign above = cnt >= ofs_x;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) flag_n <= RST_VAL;
      else                    flag_n <= above;
   end

endmodule

// File: rtl/pflag_offset_unit.sv
module pflag_offset_unit #(
   parameter int W     = 15,
   parameter int CNT_W = 16
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic [1:0]       dflt_sel,
   input  logic             parity_cfg,
   input  logic             ld,
   input  logic             ser_en,
   input  logic             ser_in,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [35:0]      din,
   input  logic [CNT_W-1:0] word_cnt,
   input  logic [CNT_W-1:0] free_cnt,
   output logic             ae_n,
   output logic             af_n,
   output logic [35:0]      dout
);
   generate
      if (W < 10 || W > 31) begin : g_bad_w
         $error("pflag_offset_unit: W must lie in 10..31");
      end
      if (CNT_W <= W) begin : g_bad_cnt
         $error("pflag_offset_unit: CNT_W must exceed W");
      end
   endgenerate

   logic [W-1:0] ofs_e;
   logic [W-1:0] ofs_f;
   logic         ser_mode;
   logic         skip_par;

   pfo_offset_regs #(.W(W)) u_regs (
      .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .dflt_sel(dflt_sel), .parity_cfg(parity_cfg), .ld(ld),
      .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en), .din(din),
      .ofs_e(ofs_e), .ofs_f(ofs_f), .ser_mode(ser_mode), .skip_par(skip_par)
   );

   pfo_readback #(.W(W)) u_rb (
      .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .rd_en(rd_en), .ld(ld), .ofs_e(ofs_e), .ofs_f(ofs_f),
      .skip_par(skip_par), .dout(dout)
   );

   pfo_flag_cmp #(.CNT_W(CNT_W), .W(W), .STRICT(1'b0), .RST_VAL(1'b0)) u_ae (
      .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cnt(word_cnt), .ofs(ofs_e), .flag_n(ae_n)
   );

   pfo_flag_cmp #(.CNT_W(CNT_W), .W(W), .STRICT(1'b1), .RST_VAL(1'b1)) u_af (
      .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cnt(free_cnt), .ofs(ofs_f), .flag_n(af_n)
   );

endmodule

// File: rtl/pfo_checker.sv
module pfo_checker #(
   parameter int W     = 15,
   parameter int CNT_W = 16
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             mrst_n,
   input logic             prst_n,
   input logic             ld,
   input logic             ser_en,
   input logic             wr_en,
   input logic             rd_en,
   input logic [CNT_W-1:0] word_cnt,
   input logic [CNT_W-1:0] free_cnt,
   input logic             ae_n,
   input logic             af_n,
   input logic [35:0]      dout,
   input logic [W-1:0]     ofs_e,
   input logic [W-1:0]     ofs_f,
   input logic             ser_mode
);
   logic [CNT_W-1:0] e_x;
   logic [CNT_W-1:0] f_x;
   assign e_x = {{(CNT_W - W){1'b0}}, ofs_e};
   assign f_x = {{(CNT_W - W){1'b0}}, ofs_f};

   assert_ae_low_R1: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
      (word_cnt < e_x) |=> !ae_n);
   assert_ae_high_R1: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
      (word_cnt >= e_x) |=> ae_n);
   assert_af_low_R2: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
      (free_cnt <= f_x) |=> !af_n);
   assert_af_high_R2: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
      (free_cnt > f_x) |=> af_n);
   assert_ser_only_R8: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (prst_n && ser_mode && !(ser_en && ld)) |=> ($stable(ofs_e) && $stable(ofs_f)));
   assert_par_only_R8: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (prst_n && !ser_mode && !(wr_en && ld)) |=> ($stable(ofs_e) && $stable(ofs_f)));
   assert_prst_keeps_R10: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(ofs_e) && $stable(ofs_f) && $stable(ser_mode)));
   assert_dout_hold_R9: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
      !(rd_en && ld) |=> $stable(dout));

endmodule

bind pflag_offset_unit pfo_checker #(.W(W), .CNT_W(CNT_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
   .ld(ld), .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en),
   .word_cnt(word_cnt), .free_cnt(free_cnt), .ae_n(ae_n), .af_n(af_n),
   .dout(dout), .ofs_e(ofs_e), .ofs_f(ofs_f), .ser_mode(ser_mode)
);

// File: tb/pflag_offset_unit_test.sv
module pflag_offset_unit_test;
   localparam int W = 15;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   always #10 clk = !clk;

   logic mrst_n = 1'b0, prst_n = 1'b1, parity_cfg = 1'b0;
   logic [1:0] dflt_sel = 2'd0;
   logic ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [35:0] din = '0;
   logic [CNT_W-1:0] word_cnt = '0, free_cnt = 16'hFFFF;
   logic ae_n, af_n;
   logic [35:0] dout;

   pflag_offset_unit #(.W(W), .CNT_W(CNT_W)) uut (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .dflt_sel(dflt_sel), .parity_cfg(parity_cfg), .ld(ld), .ser_en(ser_en),
      .ser_in(ser_in), .wr_en(wr_en), .rd_en(rd_en), .din(din),
      .word_cnt(word_cnt), .free_cnt(free_cnt), .ae_n(ae_n), .af_n(af_n), .dout(dout)
   );

   int total = 0, bad = 0;
   logic [35:0] exp_q[$];
   string tag_q[$];
   logic [W-1:0] m_e, m_f;
   logic m_ser, m_ip, m_pseq, m_rseq;

   function automatic logic [35:0] lay(input logic [W-1:0] v, input logic ip);
      logic [35:0] r;
      r = '0;
      if (!ip) begin
         r[W-1:0] = v;
      end else begin
         r[7:0] = v[7:0];
         r[15:9] = v[14:8];
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [35:0] got, input logic [35:0] expv);
      total++;
      if (got !== expv) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // scoreboard monitor: compares each read-back result with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         if (mrst_n && prst_n && rd_en && ld) begin
            #1;
            if (exp_q.size() == 0) begin
               check("R9 unexpected readback", dout, 36'h0);
            end else begin
               check(tag_q.pop_front(), dout, exp_q.pop_front());
            end
         end
      end
   end

   task automatic do_mrst(input logic [2:0] k, input logic ip);
      mrst_n = 1'b0; ld = k[2]; dflt_sel = k[1:0]; parity_cfg = ip;
      tick(); tick();
      mrst_n = 1'b1; ld = 1'b0;
      tick();
      m_e = W'((32'd8 << k) - 32'd1); m_f = m_e;
      m_ser = !k[2]; m_ip = ip; m_pseq = 1'b0; m_rseq = 1'b0;
   endtask

   task automatic do_prst();
      prst_n = 1'b0; tick(); prst_n = 1'b1; tick();
      m_pseq = 1'b0; m_rseq = 1'b0;
   endtask

   task automatic readback(input string tag);
      exp_q.push_back(lay(m_rseq ? m_f : m_e, m_ip));
      tag_q.push_back(tag);
      m_rseq = !m_rseq;
      rd_en = 1'b1; ld = 1'b1; tick();
      rd_en = 1'b0; ld = 1'b0; tick();
   endtask

   task automatic ser_bits(input logic [W-1:0] v, input int lo, input int n);
      for (int i = lo; i < lo + n; i++) begin
         ser_in = v[i]; ser_en = 1'b1; ld = 1'b1; tick();
      end
      ser_en = 1'b0; ld = 1'b0; ser_in = 1'b0;
   endtask

   task automatic par_write(input logic [35:0] d, input logic [W-1:0] v);
      din = d; wr_en = 1'b1; ld = 1'b1; tick();
      wr_en = 1'b0; ld = 1'b0; din = '0;
      if (!m_ser) begin
         if (m_pseq) m_f = v; else m_e = v;
         m_pseq = !m_pseq;
      end
   endtask

   task automatic chk_ae(input logic [CNT_W-1:0] c, input logic expv, input string tag);
      word_cnt = c; tick();
      check(tag, {35'd0, ae_n}, {35'd0, expv});
   endtask

   task automatic chk_af(input logic [CNT_W-1:0] c, input logic expv, input string tag);
      free_cnt = c; tick();
      check(tag, {35'd0, af_n}, {35'd0, expv});
   endtask

   bit finished = 1'b0;

   initial begin
      #(20 * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R3: code 2, serial, plain layout -> offsets 31
      do_mrst(3'd2, 1'b0);
      check("R3 dout after master reset", dout, 36'h0);
      check("R1 ae_n reset state", {35'd0, ae_n}, 36'h0);
      check("R2 af_n reset state", {35'd0, af_n}, 36'h1);
      chk_ae(16'd30, 1'b0, "R1 count below default");
      chk_ae(16'd31, 1'b1, "R1 count equal default");
      chk_af(16'd31, 1'b0, "R2 free equal default");
      chk_af(16'd32, 1'b1, "R2 free above default");
      readback("R3 default empty offset");
      readback("R9 default full offset");

      // R4: serial load, offset moves only on its last bit
      ser_bits(15'd100, 0, 14);
      chk_ae(16'd31, 1'b1, "R4 offset unchanged before last bit");
      chk_ae(16'd30, 1'b0, "R4 old threshold still active");
      ser_bits(15'd100, 14, 1);
      m_e = 15'd100;
      chk_ae(16'd99, 1'b0, "R4 serial empty offset below");
      chk_ae(16'd100, 1'b1, "R4 serial empty offset equal");
      ser_bits(15'd200, 0, 15);
      m_f = 15'd200;
      chk_af(16'd200, 1'b0, "R4 serial full offset equal");
      chk_af(16'd201, 1'b1, "R4 serial full offset above");
      readback("R4 readback empty");
      readback("R4 readback full");

      // R8: parallel write ignored in serial mode
      par_write(36'h5, 15'd5);
      readback("R8 parallel ignored in serial, empty");
      readback("R8 parallel ignored in serial, full");

      // R10: partial reset keeps values, restarts sequences
      readback("R10 readback before partial reset");
      do_prst();
      readback("R10 readback order restarts");
      readback("R10 full offset kept");
      ser_bits(15'h7FFF, 0, 5);
      do_prst();
      ser_bits(15'd300, 0, 15);
      ser_bits(15'd400, 0, 15);
      m_e = 15'd300; m_f = 15'd400;
      readback("R10 serial position restart, empty");
      readback("R10 serial position restart, full");

      // R7: code 5, parallel, parity skipping -> offsets 255
      do_mrst(3'd5, 1'b1);
      readback("R3 code 5 empty default");
      readback("R3 code 5 full default");
      chk_af(16'd255, 1'b0, "R2 free equal 255");
      chk_af(16'd256, 1'b1, "R2 free above 255");
      par_write(lay(15'h1234, 1'b1) | 36'h8_0402_0100, 15'h1234);
      par_write(lay(15'h0ABC, 1'b1) | 36'h8_0402_0100, 15'h0ABC);
      readback("R7 parity layout empty");
      readback("R7 parity layout full");
      par_write(lay(15'h0077, 1'b1) | 36'h0_0000_0100, 15'h0077);
      chk_ae(16'h76, 1'b0, "R5 wrapped write below");
      chk_ae(16'h77, 1'b1, "R5 wrapped write equal");
      readback("R5 wrap targets empty offset");
      readback("R5 full offset untouched by wrap");

      // R8: serial strobes ignored in parallel mode
      ser_bits(15'd0, 0, 15);
      ser_bits(15'd0, 0, 15);
      readback("R8 serial ignored in parallel, empty");
      readback("R8 serial ignored in parallel, full");

      // R6: code 7, parallel, plain layout -> offsets 1023
      do_mrst(3'd7, 1'b0);
      chk_ae(16'd1022, 1'b0, "R3 code 7 below");
      chk_ae(16'd1023, 1'b1, "R3 code 7 equal");
      par_write(36'hF_0000_0155, 15'h0155);
      par_write(36'hF_0000_4321, 15'h4321);
      readback("R6 plain layout empty");
      readback("R6 plain layout full");
      chk_af(16'h4321, 1'b0, "R6 full offset equal");
      chk_af(16'h4322, 1'b1, "R6 full offset above");

      tick(); tick();
      if (exp_q.size() != 0) check("R9 pending readbacks", 36'(exp_q.size()), 36'h0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule